// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block turns a three-wire stereo PCM stream (bit clock, word-select clock and serial data) into parallel left and right sample words. Each wire passes through a synchronizer into the system clock domain. A bit is sampled on every rising edge of the bit clock that the synchronizer sees. A static format input picks one of two framings. In right-justified framing the word is MSB first and ends on the last bit clock before the word-select edge. In I2S framing the MSB arrives one bit clock after the word-select edge.

A rate monitor counts the bit clocks in each word-select period. When a frame holds exactly 32 bit clocks, the receiver switches to a packed 16-bit mode in which every word fills its half-frame exactly. Captured words are held as an 18-bit core value and then sign-extended to the output width. A left word and the right word that follows it leave the block together, with a one-cycle valid strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted, and after it is released with no bit-clock activity, `left_o`, `right_o`, `valid_o` and `packed_o` are all zero.
- R2: With `fmt_i2s_i` = 0 and no packed mode, the 18-bit core value of a channel is the 18 bits sampled on the last 18 rising bit-clock edges before that channel's word-select edge, MSB first. Word select high marks the left channel. Earlier bits in the half-frame are ignored.
- R3: With `fmt_i2s_i` = 1 and no packed mode, the core value is the first 18 bits that follow the word-select edge, starting one bit clock after it. Word select low marks the left channel. A 20-bit word therefore loses its two LSBs. Half-frames may be 18 to 32 bit clocks long.
- R4: In I2S framing, a 16-bit word followed by zero bits comes out left-aligned in the 18-bit core value, with its two lowest bits zero.
- R5: `packed_o` rises after two consecutive word-select periods (measured rising edge to rising edge) each hold exactly 32 bit clocks. It falls after two consecutive periods that each hold a different count. A single period that disagrees with the current mode leaves `packed_o` unchanged.
- R6: While `packed_o` is 1, every 16-bit word spans its whole half-frame. The word is decoded in either framing and left-aligned, with two zero LSBs.
- R7: `left_o` and `right_o` are the 18-bit core values sign-extended to OUT_W bits; bit 17 of the core value is the sign.
- R8: `valid_o` pulses high for exactly one clock once per stereo pair, after the right word is captured. `left_o` and `right_o` change only in that cycle. A right word with no left word before it since reset, or since the last pair, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word-select (frame) clock |
| sd_i | input | 1 | Serial data, sampled on the rising bit-clock edge |
| fmt_i2s_i | input | 1 | Framing select: 0 right-justified, 1 I2S |
| left_o | output | OUT_W | Signed left sample |
| right_o | output | OUT_W | Signed right sample |
| valid_o | output | 1 | One-cycle strobe, new stereo pair on the outputs |
| packed_o | output | 1 | Packed 16-bit mode in effect |

## Verification
The assertions assume that each phase of the bit clock lasts at least three system clocks. Under that condition two bit-clock rising edges can never be seen in back-to-back cycles, and the valid strobe and the word events stay isolated. They also assume that word select and data change only around the falling edge of the bit clock, and that the format input is held steady while frames are running. The bench drives each bit-clock phase for four system clocks and moves word select and data only at the start of the low phase. It changes the format only while reset is asserted, and keeps every half-frame at 16 or 32 bit clocks.

// File: rtl/audrx_pkg.sv
`timescale 1ns/1ps
package audrx_pkg;

  localparam int CORE_W = 18;   // width of a decoded sample before extension
  localparam int PACK_W = 16;   // word width in packed mode

  typedef enum logic {
    FMT_RJ  = 1'b0,
    FMT_I2S = 1'b1
  } fmt_e;

  // One captured channel word, valid for a single cycle.
  typedef struct packed {
    logic              vld;
    logic              left;
    logic [CORE_W-1:0] data;
  } word_evt_t;

endpackage

// File: rtl/audrx_sync.sv
`timescale 1ns/1ps
module audrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bck,
  input  logic ws,
  input  logic sd,
  output logic tick,
  output logic ws_s,
  output logic sd_s
);

  localparam int NSIG = 3;

  logic [STAGES-1:0][NSIG-1:0] chain_q, chain_n;
  logic                        bck_d_q, bck_d_n;
  logic [NSIG-1:0]             tail;

  assign tail = chain_q[STAGES-1];

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_n = {bck, ws, sd};
    end else begin : g_multi
      always_comb chain_n = {chain_q[STAGES-2:0], {bck, ws, sd}};
    end
  endgenerate

  assign bck_d_n = tail[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      bck_d_q <= 1'b0;
    end else begin
      chain_q <= chain_n;
      bck_d_q <= bck_d_n;
    end
  end

  assign tick = tail[2] & ~bck_d_q;
  assign ws_s = tail[1];
  assign sd_s = tail[0];

  // Bit-clock rising edges are isolated; the rest of the receiver relies on it.
  p_tick_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/audrx_rate_det.sv
`timescale 1ns/1ps
module audrx_rate_det #(
  parameter int PACKED_BCK = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ws_s,
  output logic packed_mode
);

  localparam int CNT_W = $clog2(2 * PACKED_BCK + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_PK  = CNT_W'(PACKED_BCK);

  logic             ws_d_q, ws_d_n;
  logic             primed_q, primed_n;
  logic             armed_q, armed_n;
  logic             last_q, last_n;
  logic             packed_q, packed_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             rise;
  logic             cand;

  assign rise = tick & primed_q & ws_s & ~ws_d_q;
  assign cand = (cnt_q == CNT_PK);

  always_comb begin
    ws_d_n   = ws_d_q;
    primed_n = primed_q;
    armed_n  = armed_q;
    last_n   = last_q;
    packed_n = packed_q;
    cnt_n    = cnt_q;
    if (tick) begin
      ws_d_n   = ws_s;
      primed_n = 1'b1;
      if (rise) begin
        cnt_n   = CNT_W'(1);
        armed_n = 1'b1;
        if (armed_q) begin
          last_n = cand;
          if (cand == last_q) packed_n = cand;
        end
      end else if (cnt_q != CNT_MAX) begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_d_q   <= 1'b0;
      primed_q <= 1'b0;
      armed_q  <= 1'b0;
      last_q   <= 1'b0;
      packed_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      ws_d_q   <= ws_d_n;
      primed_q <= primed_n;
      armed_q  <= armed_n;
      last_q   <= last_n;
      packed_q <= packed_n;
      cnt_q    <= cnt_n;
    end
  end

  assign packed_mode = packed_q;

  // Mode changes only right after a word-select rising edge.
  p_mode_at_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(packed_q) |-> $past(rise));

endmodule

// File: rtl/audrx_deser.sv
`timescale 1ns/1ps
module audrx_deser
  import audrx_pkg::*;
#(
  parameter int SR_W = 32
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      ws_s,
  input  logic      sd_s,
  input  logic      fmt_i2s,
  input  logic      packed_mode,
  output word_evt_t evt
);

  localparam int HL_W = $clog2(SR_W + 1);
  localparam int PAD  = CORE_W - PACK_W;
  localparam logic [HL_W-1:0] HL_MAX = HL_W'(SR_W);
  localparam logic [HL_W-1:0] HL_CORE = HL_W'(CORE_W);

  fmt_e              fmt;
  logic [SR_W-2:0]   sr_q, sr_n;
  logic [SR_W-1:0]   sr_shift;
  logic              ws_prev_q, ws_prev_n;
  logic              primed_q, primed_n;
  logic              started_q, started_n;
  logic [HL_W-1:0]   hlen_q, hlen_n;
  logic [HL_W-1:0]   sh;
  logic [CORE_W-1:0] win;
  logic [CORE_W-1:0] word_sel;
  word_evt_t         evt_q, evt_n;

  assign fmt      = fmt_e'(fmt_i2s);
  assign sr_shift = {sr_q, sd_s};
  assign sh       = (hlen_q > HL_CORE) ? hlen_q - HL_CORE : '0;
  assign win      = CORE_W'(sr_shift >> sh);

  // Word window chosen by framing and packed mode.
  always_comb begin
    unique case ({fmt, packed_mode})
      {FMT_RJ,  1'b0}: word_sel = sr_q[CORE_W-1:0];
      {FMT_RJ,  1'b1}: word_sel = {sr_q[PACK_W-1:0], {PAD{1'b0}}};
      {FMT_I2S, 1'b1}: word_sel = {sr_shift[PACK_W-1:0], {PAD{1'b0}}};
      default:         word_sel = win;
    endcase
  end

  always_comb begin
    sr_n      = sr_q;
    ws_prev_n = ws_prev_q;
    primed_n  = primed_q;
    started_n = started_q;
    hlen_n    = hlen_q;
    evt_n     = '0;
    if (tick) begin
      sr_n      = sr_shift[SR_W-2:0];
      ws_prev_n = ws_s;
      primed_n  = 1'b1;
      if (primed_q && (ws_s != ws_prev_q)) begin
        hlen_n    = HL_W'(1);
        started_n = 1'b1;
        if (started_q) begin
          evt_n.vld  = 1'b1;
          evt_n.left = (fmt == FMT_I2S) ? ~ws_prev_q : ws_prev_q;
          evt_n.data = word_sel;
        end
      end else if (hlen_q != HL_MAX) begin
        hlen_n = hlen_q + HL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q      <= '0;
      ws_prev_q <= 1'b0;
      primed_q  <= 1'b0;
      started_q <= 1'b0;
      hlen_q    <= '0;
      evt_q     <= '0;
    end else begin
      sr_q      <= sr_n;
      ws_prev_q <= ws_prev_n;
      primed_q  <= primed_n;
      started_q <= started_n;
      hlen_q    <= hlen_n;
      evt_q     <= evt_n;
    end
  end

  assign evt = evt_q;

  // A word event always follows a sampled bit-clock edge.
  p_word_after_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q.vld |-> $past(tick));

  // The half-frame counter never runs past the history window.
  p_hlen_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hlen_q <= HL_MAX);

endmodule

// File: rtl/audrx_pair.sv
`timescale 1ns/1ps
module audrx_pair
  import audrx_pkg::*;
#(
  parameter int OUT_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  word_evt_t               evt,
  output logic signed [OUT_W-1:0] left,
  output logic signed [OUT_W-1:0] right,
  output logic                    valid
);

  localparam int EXT = OUT_W - CORE_W;

  logic [CORE_W-1:0] hold_q, hold_n;
  logic              have_q, have_n;
  logic [OUT_W-1:0]  left_q, left_n;
  logic [OUT_W-1:0]  right_q, right_n;
  logic              valid_q, valid_n;

  function automatic logic [OUT_W-1:0] sext(input logic [CORE_W-1:0] d);
    return {{EXT{d[CORE_W-1]}}, d};
  endfunction

  always_comb begin
    hold_n  = hold_q;
    have_n  = have_q;
    left_n  = left_q;
    right_n = right_q;
    valid_n = 1'b0;
    if (evt.vld) begin
      if (evt.left) begin
        hold_n = evt.data;
        have_n = 1'b1;
      end else if (have_q) begin
        left_n  = sext(hold_q);
        right_n = sext(evt.data);
        valid_n = 1'b1;
        have_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      have_q  <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
    end else begin
      hold_q  <= hold_n;
      have_q  <= have_n;
      left_q  <= left_n;
      right_q <= right_n;
      valid_q <= valid_n;
    end
  end

  assign left  = left_q;
  assign right = right_q;
  assign valid = valid_q;

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(left_q) && $stable(right_q)) |-> valid_q);

  p_pair_needs_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(have_q));

  p_sign_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ($countones(left_q[OUT_W-1:CORE_W-1]) == 0 ||
                 $countones(left_q[OUT_W-1:CORE_W-1]) == EXT + 1));

endmodule

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx
  import audrx_pkg::*;
#(
  parameter int OUT_W       = 24,
  parameter int SR_W        = 32,
  parameter int PACKED_BCK  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bck_i,
  input  logic                    ws_i,
  input  logic                    sd_i,
  input  logic                    fmt_i2s_i,
  output logic signed [OUT_W-1:0] left_o,
  output logic signed [OUT_W-1:0] right_o,
  output logic                    valid_o,
  output logic                    packed_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       tick;
  logic       ws_s;
  logic       sd_s;
  logic       packed_mode;
  word_evt_t  evt;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  audrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .bck   (bck_i),
    .ws    (ws_i),
    .sd    (sd_i),
    .tick  (tick),
    .ws_s  (ws_s),
    .sd_s  (sd_s)
  );

  audrx_rate_det #(.PACKED_BCK(PACKED_BCK)) u_rate (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .tick        (tick),
    .ws_s        (ws_s),
    .packed_mode (packed_mode)
  );

  audrx_deser #(.SR_W(SR_W)) u_deser (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .tick        (tick),
    .ws_s        (ws_s),
    .sd_s        (sd_s),
    .fmt_i2s     (fmt_i2s_i),
    .packed_mode (packed_mode),
    .evt         (evt)
  );

  audrx_pair #(.OUT_W(OUT_W)) u_pair (
    .clk   (clk),
    .rst_n (rst_core_n),
    .evt   (evt),
    .left  (left_o),
    .right (right_o),
    .valid (valid_o)
  );

  assign packed_o = packed_mode;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_core_n |-> (!valid_o && !packed_o && left_o == '0 && right_o == '0));

endmodule

// File: tb/tb_serial_audio_rx.sv
`timescale 1ns/1ps
module tb_serial_audio_rx;

  localparam int OW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bck = 1'b1;
  logic ws = 1'b0;
  logic sd = 1'b0;
  logic fmt = 1'b0;
  logic signed [OW-1:0] left_o, right_o;
  logic valid_o, packed_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic pend = 1'b0;

  logic [OW-1:0] cap_l [256];
  logic [OW-1:0] cap_r [256];
  int cap_n = 0;
  int vwide = 0;
  logic vprev = 1'b0;

  always #2.5 clk = ~clk;

  serial_audio_rx dut (
    .clk(clk), .rst_n(rst_n), .bck_i(bck), .ws_i(ws), .sd_i(sd),
    .fmt_i2s_i(fmt), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o), .packed_o(packed_o)
  );

  always @(negedge clk) begin
    if (valid_o) begin
      if (cap_n < 256) begin
        cap_l[cap_n] = left_o;
        cap_r[cap_n] = right_o;
      end
      cap_n = cap_n + 1;
      if (vprev) vwide = vwide + 1;
    end
    vprev = valid_o;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gen(input int k);
    return (32'h9E3779B9 * (k + 3)) ^ (32'h5A5A5A5A >> (k % 7));
  endfunction

  // kind 0: 18-bit right-justified, 1: 20-bit truncated, 2: 16-bit left-aligned
  function automatic logic [OW-1:0] expect_word(input int kind, input logic [31:0] w);
    logic [17:0] c;
    case (kind)
      0: c = w[17:0];
      1: c = w[19:2];
      default: c = {w[15:0], 2'b00};
    endcase
    return {{(OW-18){c[17]}}, c};
  endfunction

  function automatic logic left_ws();
    return fmt ? 1'b0 : 1'b1;
  endfunction

  task automatic bit_tick(input logic w, input logic d);
    @(posedge clk);
    bck <= 1'b0; ws <= w; sd <= d;
    repeat (4) @(posedge clk);
    bck <= 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic send_half(input logic w, input int h, input int wl, input logic [31:0] word);
    for (int i = 0; i < h; i++) begin
      logic d;
      if (fmt) begin
        if (i == 0) d = pend;
        else d = ((i - 1) < wl) ? word[wl - i] : 1'b0;
      end else begin
        d = ((h - 1 - i) < wl) ? word[h - 1 - i] : 1'b1;
      end
      bit_tick(w, d);
    end
    pend = (fmt && wl == h) ? word[0] : 1'b0;
  endtask

  task automatic send_frame(input int h, input int wl, input logic [31:0] lw, input logic [31:0] rw);
    send_half(left_ws(), h, wl, lw);
    send_half(~left_ws(), h, wl, rw);
  endtask

  task automatic start(input logic f, input logic idle_ws);
    rst_n <= 1'b0;
    fmt <= f;
    bck <= 1'b1; ws <= idle_ws; sd <= 1'b0;
    pend = 1'b0;
    repeat (6) @(posedge clk);
    rst_n <= 1'b1;
    repeat (6) @(posedge clk);
    for (int i = 0; i < 3; i++) bit_tick(idle_ws, 1'b0);
  endtask

  task automatic trail(input int h);
    send_half(left_ws(), h, h, 32'h0);
    repeat (20) @(posedge clk);
  endtask

  task automatic run_stream(input string req, input logic f, input int h, input int wl,
                            input int kind, input int n, input int first);
    int base;
    start(f, f ? 1'b1 : 1'b0);
    base = cap_n;
    for (int k = 0; k < n; k++) send_frame(h, wl, gen(2*k), gen(2*k+1));
    trail(h);
    chk({req, " pair count R8"}, cap_n - base, n);
    for (int k = first; k < n; k++) begin
      chk({req, " left"}, cap_l[base+k], expect_word(kind, gen(2*k)));
      chk({req, " right"}, cap_r[base+k], expect_word(kind, gen(2*k+1)));
    end
  endtask

  task automatic t_reset();
    rst_n <= 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 valid in reset", valid_o, 0);
    chk("R1 packed in reset", packed_o, 0);
    chk("R1 left in reset", left_o, 0);
    chk("R1 right in reset", right_o, 0);
    rst_n <= 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 outputs idle", {valid_o, packed_o, left_o, right_o}, 0);
  endtask

  task automatic t_rj18();
    int base;
    run_stream("R2 rj18", 1'b0, 32, 18, 0, 4, 0);
    chk("R2 packed stays low", packed_o, 0);
    // R7: explicit negative and positive core values
    start(1'b0, 1'b0);
    base = cap_n;
    send_frame(32, 18, 32'h20001, 32'h1FFFF);
    trail(32);
    chk("R7 negative sign fill", cap_l[base], 24'hFE0001);
    chk("R7 positive sign fill", cap_r[base], 24'h01FFFF);
  endtask

  task automatic t_i2s20();
    run_stream("R3 i2s20", 1'b1, 32, 20, 1, 4, 0);
  endtask

  task automatic t_i2s16();
    run_stream("R4 i2s16", 1'b1, 32, 16, 2, 4, 0);
  endtask

  task automatic t_packed_rj();
    run_stream("R6 packed rj", 1'b0, 16, 16, 2, 8, 4);
    chk("R5 packed rj detect", packed_o, 1);
  endtask

  task automatic t_packed_i2s();
    run_stream("R6 packed i2s", 1'b1, 16, 16, 2, 8, 4);
    chk("R5 packed i2s detect", packed_o, 1);
  endtask

  task automatic t_glitch();
    start(1'b0, 1'b0);
    for (int k = 0; k < 6; k++) send_frame(16, 16, gen(k), gen(k+9));
    chk("R5 glitch pre", packed_o, 1);
    send_frame(32, 18, 32'h1234, 32'h4321);
    for (int k = 0; k < 3; k++) send_frame(16, 16, gen(k), gen(k+9));
    repeat (20) @(posedge clk);
    chk("R5 single odd frame ignored", packed_o, 1);
    send_frame(32, 18, 32'h1, 32'h2);
    send_frame(32, 18, 32'h3, 32'h4);
    trail(32);
    chk("R5 leaves packed after two frames", packed_o, 0);
  endtask

  task automatic t_orphan();
    int base;
    start(1'b0, 1'b1);
    base = cap_n;
    send_half(1'b0, 32, 18, 32'h15555);
    for (int k = 0; k < 3; k++) send_frame(32, 18, gen(40+k), gen(50+k));
    trail(32);
    chk("R8 orphan right dropped count", cap_n - base, 3);
    chk("R8 first pair left", cap_l[base], expect_word(0, gen(40)));
    chk("R8 first pair right", cap_r[base], expect_word(0, gen(50)));
    chk("R8 strobe width", vwide, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_rj18();
    t_i2s20();
    t_i2s16();
    t_packed_rj();
    t_packed_i2s();
    t_glitch();
    t_orphan();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule